// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block samples 32 general-purpose input pins and turns selected conditions on them into one interrupt request for the processor. Each pin is configured through a small 16-bit register bus. A pin can be level sensitive with a chosen polarity, or edge sensitive on rising edges, falling edges or both. An edge-sensitive pin either latches its event until software acknowledges it or passes the event straight through as a single-cycle pulse.

Every per-pin register is 32 bits wide and is split into two 16-bit halves. The low half covers pins 0 to 15. The high half covers pins 16 to 31 and sits at the low half's byte offset plus 2. Status bits collect events whether or not a pin is enabled. The interrupt output is a registered OR over all pins of status AND enable.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every enable, trigger, polarity, hold, falling and rising bit is 0, and `irq_o` is 0.
- R2: The registers sit at these byte offsets (low half / high half): status 0x08/0x0A, enable 0x0C/0x0E, trigger 0x10/0x12, polarity 0x14/0x16, hold 0x18/0x1A, falling 0x20/0x22, rising 0x24/0x26. A write to one half leaves the other half unchanged. A read returns data one cycle later, with `rd_vld_o` high. Reads from any other offset, or from an odd offset, return 0, and writes there have no effect.
- R3: A pin whose trigger bit is 0 is level sensitive. Its status bit follows the synchronised pin, active-high when its polarity bit is 1 and active-low when it is 0. The status bit is never latched, so writing 1 to it has no lasting effect.
- R4: A pin with trigger=1, hold=1 and rising=1 sets its status bit on a 0-to-1 pin change. The bit stays set after the pin returns to 0.
- R5: The falling bit enables detection of 1-to-0 changes. With falling=1 and rising=0, a rising change sets nothing. With both bits set, either change sets the status bit.
- R6: An edge pin with hold=0 shows its event in status for exactly one cycle. It is not retained.
- R7: Writing 1 to a latched status bit clears it. Writing 0 leaves it unchanged.
- R8: If a new latched event and a write-one-to-clear reach the same status bit in the same cycle, the bit stays set.
- R9: Status bits record events regardless of enable. `irq_o` is the registered OR of (status AND enable) over all pins.
- R10: A pin change driven between clock edges reaches the status register at the third rising edge and reaches `irq_o` at the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous pin inputs |
| addr_i | input | 6 | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 16 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 16 | Read data, valid one cycle after the strobe |
| rd_vld_o | output | 1 | Read data valid |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench goes after a write-one-to-clear that lands in the same cycle as a fresh edge. A design that lets the clear win would lose that interrupt. It times a pass-through edge cycle by cycle, which catches a pipeline with an extra stage or a pulse that lingers. It checks that level pins cannot be acknowledged and that a falling-only pin ignores rising changes, which catches mixed-up enable bits. It also checks that a half-register write leaves the other half alone and that unmapped offsets read as zero, which catches decode or masking faults.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int DW   = 16,
  parameter int AW   = 6,
  parameter int NPIN = 2 * DW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_i,
  input  logic [AW-1:0]   addr_i,
  input  logic            wr_en_i,
  input  logic [DW-1:0]   wr_data_i,
  input  logic            rd_en_i,
  output logic [DW-1:0]   rd_data_o,
  output logic            rd_vld_o,
  output logic            irq_o
);
  localparam logic [AW-1:0] A_STAT = AW'('h08);
  localparam logic [AW-1:0] A_EN   = AW'('h0C);
  localparam logic [AW-1:0] A_TYP  = AW'('h10);
  localparam logic [AW-1:0] A_POL  = AW'('h14);
  localparam logic [AW-1:0] A_HOLD = AW'('h18);
  localparam logic [AW-1:0] A_FALL = AW'('h20);
  localparam logic [AW-1:0] A_RISE = AW'('h24);

  logic [NPIN-1:0] stat, en, typ, pol, hold, fen, ren;
  logic [NPIN-1:0] s1, s2, prv;

  wire            hi    = addr_i[1];
  wire            hit   = !addr_i[0];
  wire [AW-1:0]   base  = {addr_i[AW-1:2], 2'b00};
  wire [NPIN-1:0] wvec  = hi ? {wr_data_i, {DW{1'b0}}} : {{DW{1'b0}}, wr_data_i};
  wire [NPIN-1:0] hmask = hi ? {{DW{1'b1}}, {DW{1'b0}}} : {{DW{1'b0}}, {DW{1'b1}}};
  wire            wr_ok = wr_en_i && hit;

  wire [NPIN-1:0] clr   = (wr_ok && base == A_STAT) ? wvec : '0;
  wire [NPIN-1:0] rise  = s2 & ~prv;
  wire [NPIN-1:0] fall  = ~s2 & prv;
  wire [NPIN-1:0] evt   = typ & ((rise & ren) | (fall & fen));
  wire [NPIN-1:0] lvl   = ~typ & ~(s2 ^ pol);
  wire [NPIN-1:0] latch = typ & hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= '0;
      s2  <= '0;
      prv <= '0;
    end else begin
      s1  <= pin_i;
      s2  <= s1;
      prv <= s2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      typ  <= '0;
      pol  <= '0;
      hold <= '0;
      fen  <= '0;
      ren  <= '0;
    end else if (wr_ok) begin
      case (base)
        A_EN:    en   <= (en   & ~hmask) | wvec;
        A_TYP:   typ  <= (typ  & ~hmask) | wvec;
        A_POL:   pol  <= (pol  & ~hmask) | wvec;
        A_HOLD:  hold <= (hold & ~hmask) | wvec;
        A_FALL:  fen  <= (fen  & ~hmask) | wvec;
        A_RISE:  ren  <= (ren  & ~hmask) | wvec;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat  <= '0;
      irq_o <= 1'b0;
    end else begin
      stat  <= (latch & ((stat & ~clr) | evt)) | (~latch & (evt | lvl));
      irq_o <= |(stat & en);
    end
  end

  logic [NPIN-1:0] rv;
  always_comb begin
    rv = '0;
    if (hit) begin
      case (base)
        A_STAT:  rv = stat;
        A_EN:    rv = en;
        A_TYP:   rv = typ;
        A_POL:   rv = pol;
        A_HOLD:  rv = hold;
        A_FALL:  rv = fen;
        A_RISE:  rv = ren;
        default: rv = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
      rd_vld_o  <= 1'b0;
    end else begin
      rd_vld_o  <= rd_en_i;
      if (rd_en_i) rd_data_o <= hi ? rv[NPIN-1:DW] : rv[DW-1:0];
    end
  end
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NPIN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_en_i,
  input logic            rd_vld_o,
  input logic            irq_o,
  input logic [NPIN-1:0] stat,
  input logic [NPIN-1:0] en,
  input logic [NPIN-1:0] typ,
  input logic [NPIN-1:0] hold,
  input logic [NPIN-1:0] latch,
  input logic [NPIN-1:0] evt
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!irq_o && en == '0));

  // R2
  rd_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_vld_o);

  // R2
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_vld_o);

  // R8
  held_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch & evt) != '0) |=> ((stat & $past(latch & evt)) == $past(latch & evt)));

  // R6
  pass_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat & $past(typ & ~hold)) == $past(evt & typ & ~hold)));

  // R9
  irq_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en) == '0) |=> !irq_o);

  // R9
  irq_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & en) != '0) |=> irq_o);
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPIN(NPIN)) i_chk (
  .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .rd_vld_o(rd_vld_o),
  .irq_o(irq_o), .stat(stat), .en(en), .typ(typ), .hold(hold),
  .latch(latch), .evt(evt)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic [5:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic        rd_en = 1'b0;
  logic [15:0] rdata;
  logic        rvld;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  logic [15:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .addr_i(addr),
    .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
    .rd_data_o(rdata), .rd_vld_o(rvld), .irq_o(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] e, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    q_exp.push_back(e);
    q_tag.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  always @(negedge clk) begin
    if (rvld) begin
      if (q_exp.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 unexpected read data actual=%h expected=none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        checks++;
        if (rdata !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  initial begin
    #500000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(2);
    // R1 all configuration zero, irq low
    chk_irq(1'b0, "R1");
    for (int a = 'h0C; a <= 'h26; a += 2)
      if (a != 'h1C && a != 'h1E) rd(6'(a), 16'h0000, "R1 reset value");
    // R3 level pins default active-low, pins low -> asserted; R9 no irq when disabled
    rd(6'h08, 16'hFFFF, "R3 active-low status");
    rd(6'h0A, 16'hFFFF, "R3 active-low status high");
    chk_irq(1'b0, "R9 disabled");

    // R2 half writes and unmapped space
    wr(6'h0C, 16'hA5A5);
    wr(6'h0E, 16'h5A5A);
    rd(6'h0C, 16'hA5A5, "R2 enable low");
    rd(6'h0E, 16'h5A5A, "R2 enable high");
    wr(6'h1C, 16'hFFFF);
    wr(6'h11, 16'hFFFF);
    rd(6'h1C, 16'h0000, "R2 unmapped read");
    rd(6'h00, 16'h0000, "R2 unmapped zero");
    rd(6'h10, 16'h0000, "R2 odd write ignored");
    rd(6'h0D, 16'h0000, "R2 odd read zero");
    wr(6'h0C, 16'h0000);
    wr(6'h0E, 16'h0000);
    rd(6'h0C, 16'h0000, "R2 enable cleared");

    // R3 active-high level
    wr(6'h14, 16'hFFFF);
    wr(6'h16, 16'hFFFF);
    tick(2);
    rd(6'h08, 16'h0000, "R3 active-high idle");
    @(negedge clk); pins[3] = 1'b1;
    tick(4);
    rd(6'h08, 16'h0008, "R3 level follows pin");
    wr(6'h08, 16'hFFFF);
    tick(1);
    rd(6'h08, 16'h0008, "R3 level not clearable");
    @(negedge clk); pins[3] = 1'b0;
    tick(4);
    rd(6'h08, 16'h0000, "R3 level released");

    // R4 latched rising on pin 20
    wr(6'h12, 16'h0010);
    wr(6'h1A, 16'h0010);
    wr(6'h26, 16'h0010);
    tick(2);
    rd(6'h0A, 16'h0000, "R4 idle");
    @(negedge clk); pins[20] = 1'b1;
    tick(4);
    rd(6'h0A, 16'h0010, "R4 rise latched");
    @(negedge clk); pins[20] = 1'b0;
    tick(4);
    rd(6'h0A, 16'h0010, "R4 kept after pin low");
    // R7 write zero keeps, write one clears
    wr(6'h0A, 16'h0000);
    rd(6'h0A, 16'h0010, "R7 write zero keeps");
    wr(6'h0A, 16'h0010);
    rd(6'h0A, 16'h0000, "R7 write one clears");

    // R5 falling only on pin 21
    wr(6'h12, 16'h0070);
    wr(6'h1A, 16'h0070);
    wr(6'h22, 16'h0060);
    wr(6'h26, 16'h0050);
    tick(2);
    @(negedge clk); pins[21] = 1'b1;
    tick(4);
    rd(6'h0A, 16'h0000, "R5 rise ignored by falling-only");
    @(negedge clk); pins[21] = 1'b0;
    tick(4);
    rd(6'h0A, 16'h0020, "R5 fall detected");
    wr(6'h0A, 16'h0020);
    // R5 both edges on pin 22
    @(negedge clk); pins[22] = 1'b1;
    tick(4);
    rd(6'h0A, 16'h0040, "R5 both: rise");
    wr(6'h0A, 16'h0040);
    rd(6'h0A, 16'h0000, "R5 both: cleared");
    @(negedge clk); pins[22] = 1'b0;
    tick(4);
    rd(6'h0A, 16'h0040, "R5 both: fall");
    wr(6'h0A, 16'h0040);

    // R6 pass-through edge on pin 1, R10 latency
    wr(6'h10, 16'h0002);
    wr(6'h18, 16'h0000);
    wr(6'h24, 16'h0002);
    wr(6'h0C, 16'h0002);
    tick(3);
    chk_irq(1'b0, "R6 idle");
    @(negedge clk); pins[1] = 1'b1;
    @(negedge clk); chk_irq(1'b0, "R10 edge 1");
    @(negedge clk); chk_irq(1'b0, "R10 edge 2");
    @(negedge clk); chk_irq(1'b0, "R10 edge 3");
    @(negedge clk); chk_irq(1'b1, "R10 edge 4");
    @(negedge clk); chk_irq(1'b0, "R6 one-cycle pulse");
    rd(6'h08, 16'h0000, "R6 not retained");
    wr(6'h0C, 16'h0000);

    // R9 status independent of enable
    @(negedge clk); pins[20] = 1'b1;
    tick(5);
    chk_irq(1'b0, "R9 masked");
    rd(6'h0A, 16'h0010, "R9 status while masked");
    wr(6'h0E, 16'h0010);
    tick(2);
    chk_irq(1'b1, "R9 enabled");
    wr(6'h0A, 16'h0010);
    tick(2);
    chk_irq(1'b0, "R9 cleared");

    // R8 clear collides with new event
    @(negedge clk); pins[20] = 1'b0;
    tick(4);
    @(negedge clk); pins[20] = 1'b1;
    tick(4);
    @(negedge clk); pins[20] = 1'b0;
    tick(4);
    rd(6'h0A, 16'h0010, "R8 pre-set");
    @(negedge clk); pins[20] = 1'b1;
    @(negedge clk);
    wr(6'h0A, 16'h0010);
    tick(1);
    rd(6'h0A, 16'h0010, "R8 event wins over clear");

    tick(4);
    while (q_exp.size() != 0) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule